// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control state machine of a processor that spends several clock cycles on each instruction. It sits beside a datapath with one shared memory, an instruction register, a register file, a single ALU and a branch-target register. It reads the 6-bit opcode held in the instruction register. Every cycle it drives all of the datapath's write enables and multiplexer selects, and a 2-bit code for the kind of ALU operation.

It is a Moore machine. Its outputs depend only on the current state. Every instruction begins with a fetch cycle and a decode cycle. The machine then branches into a short chain of states for the instruction's class. Five classes are handled: register-register ALU operations, OR with an immediate, load word, store word and branch-if-equal. Loads and stores share one address-computation state. The datapath's address inputs therefore settle one full cycle before any memory write enable rises, which keeps the memory free of an address/enable race. Each class takes its own number of cycles.

The opcode input is not sampled on a handshake. The instruction register must hold it from the decode cycle until the instruction's last cycle. Control pins are plain level signals.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) places the machine in the fetch state. The cycle after that edge shows fetch outputs, even when reset arrives mid-instruction.
- R2: In fetch, `pc_wr`=1 and `ir_wr`=1, and every other enable is 0. Both ALU operand selects and `pc_src` are 0, and `addr_sel`=0. The ALU class is Add. ALU class encoding throughout: Add=00, Sub=01, Or=10, Reg-op=11.
- R3: In decode, `br_wr`=1 and `ext_sign`=1. The ALU class is Add, `alu_a_sel`=0 and `alu_b_sel`=10 (PC plus the shifted offset). All other outputs are 0.
- R4: Decode dispatches on opcode: 000000 Reg-op, 001101 ori, 100011 lw, 101011 sw, 000100 beq. Any other opcode returns to fetch after decode, so that instruction lasts 2 cycles.
- R5: beq lasts 3 cycles. Its third cycle drives `pc_wr_cond`=1, `pc_src`=1, class Sub, `alu_a_sel`=1 and `alu_b_sel`=01.
- R6: A Reg-op lasts 4 cycles. The execute cycle drives class Reg-op, `alu_a_sel`=1, `alu_b_sel`=01 and `reg_dst`=1. The finish cycle drives the same values plus `reg_wr`=1, with `mem_to_reg`=0.
- R7: ori lasts 4 cycles. Both of its last two cycles drive class Or, `alu_a_sel`=1, `alu_b_sel`=11 and `ext_sign`=0. The second adds `reg_wr`=1 with `reg_dst`=0.
- R8: sw lasts 4 cycles. The address cycle drives class Add, `ext_sign`=1, `alu_a_sel`=1 and `alu_b_sel`=11. `mem_wr`=1 appears only in the following cycle, with those address selects held unchanged.
- R9: lw lasts 5 cycles. It runs through the same address cycle, then a read cycle with `addr_sel`=1, then a write-back cycle with `reg_wr`=1, `mem_to_reg`=1 and `reg_dst`=0. The address selects are held through both.
- R10: In no cycle are two of `reg_wr`, `mem_wr`, `pc_wr_cond` and `br_wr` high together, and `ir_wr` always equals `pc_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset to fetch, active high |
| opcode | input | 6 | Opcode field from the instruction register |
| pc_wr | output | 1 | Unconditional program-counter write |
| pc_wr_cond | output | 1 | Program-counter write when the ALU reports zero |
| ir_wr | output | 1 | Instruction-register load |
| br_wr | output | 1 | Branch-target register load |
| mem_wr | output | 1 | Memory write enable |
| reg_wr | output | 1 | Register-file write enable |
| addr_sel | output | 1 | Memory address source: 0 PC, 1 ALU result |
| reg_dst | output | 1 | Destination field: 0 rt, 1 rd |
| mem_to_reg | output | 1 | Write-back source: 0 ALU, 1 memory |
| ext_sign | output | 1 | Immediate extension: 1 sign, 0 zero |
| alu_a_sel | output | 1 | ALU operand A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU operand B: 00 constant 4, 01 register B, 10 shifted offset, 11 extended immediate |
| pc_src | output | 1 | PC source: 0 ALU result, 1 branch target |
| alu_class | output | 2 | ALU operation class (Add 00, Sub 01, Or 10, Reg-op 11) |

## Verification
The assertions rely on two things about the inputs. Reset is only sampled at clock edges. The opcode behaves like an instruction-register field: constant from the decode cycle to the last cycle of the instruction. Under those terms, a memory write is always preceded by an address cycle with matching selects, and a load read is always followed by its write-back. The stimulus changes the opcode only while the machine shows fetch outputs. A mid-instruction reset is applied while the opcode stays put. An opcode outside the five classes exercises the early return from decode.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  typedef enum logic [3:0] {
    S_FETCH   = 4'd0,
    S_DECODE  = 4'd1,
    S_BR_DONE = 4'd2,
    S_REG_EX  = 4'd3,
    S_REG_FIN = 4'd4,
    S_IMM_EX  = 4'd5,
    S_IMM_FIN = 4'd6,
    S_ADDR    = 4'd7,
    S_ST_MEM  = 4'd8,
    S_LD_MEM  = 4'd9,
    S_LD_WB   = 4'd10
  } state_t;

  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_OR  = 2'b10,
    ALU_REG = 2'b11
  } alu_class_t;

  typedef enum logic [1:0] {
    B_FOUR = 2'b00,
    B_REGB = 2'b01,
    B_OFFS = 2'b10,
    B_IMM  = 2'b11
  } b_sel_t;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       ir_wr;
    logic       br_wr;
    logic       mem_wr;
    logic       reg_wr;
    logic       addr_sel;
    logic       reg_dst;
    logic       mem_to_reg;
    logic       ext_sign;
    logic       alu_a_sel;
    b_sel_t     alu_b_sel;
    logic       pc_src;
    alu_class_t alu_class;
  } ctrl_t;

endpackage

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
  import mc_ctrl_pkg::*;
#(
  parameter int              OP_W   = 6,
  parameter logic [OP_W-1:0] OP_REG = 6'b000000,
  parameter logic [OP_W-1:0] OP_ORI = 6'b001101,
  parameter logic [OP_W-1:0] OP_LW  = 6'b100011,
  parameter logic [OP_W-1:0] OP_SW  = 6'b101011,
  parameter logic [OP_W-1:0] OP_BEQ = 6'b000100
) (
  input  state_t          state,
  input  logic [OP_W-1:0] opcode,
  output state_t          nxt
);

  always_comb begin
    nxt = S_FETCH;
    unique case (state)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        if (opcode == OP_BEQ)                        nxt = S_BR_DONE;
        else if (opcode == OP_REG)                   nxt = S_REG_EX;
        else if (opcode == OP_ORI)                   nxt = S_IMM_EX;
        else if (opcode == OP_LW || opcode == OP_SW) nxt = S_ADDR;
        else                                         nxt = S_FETCH;
      end
      S_ADDR:   nxt = (opcode == OP_SW) ? S_ST_MEM : S_LD_MEM;
      S_REG_EX: nxt = S_REG_FIN;
      S_IMM_EX: nxt = S_IMM_FIN;
      S_LD_MEM: nxt = S_LD_WB;
      default:  nxt = S_FETCH;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_out.sv
module mc_ctrl_out
  import mc_ctrl_pkg::*;
(
  input  state_t state,
  output ctrl_t  ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (state)
      S_FETCH: begin
        ctrl.pc_wr = 1'b1;
        ctrl.ir_wr = 1'b1;
      end
      S_DECODE: begin
        ctrl.br_wr     = 1'b1;
        ctrl.ext_sign  = 1'b1;
        ctrl.alu_b_sel = B_OFFS;
      end
      S_BR_DONE: begin
        ctrl.pc_wr_cond = 1'b1;
        ctrl.pc_src     = 1'b1;
        ctrl.alu_class  = ALU_SUB;
        ctrl.alu_a_sel  = 1'b1;
        ctrl.alu_b_sel  = B_REGB;
      end
      S_REG_EX, S_REG_FIN: begin
        ctrl.alu_class = ALU_REG;
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = B_REGB;
        ctrl.reg_dst   = 1'b1;
        ctrl.reg_wr    = (state == S_REG_FIN);
      end
      S_IMM_EX, S_IMM_FIN: begin
        ctrl.alu_class = ALU_OR;
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = B_IMM;
        ctrl.reg_wr    = (state == S_IMM_FIN);
      end
      S_ADDR, S_ST_MEM, S_LD_MEM, S_LD_WB: begin
        ctrl.ext_sign   = 1'b1;
        ctrl.alu_a_sel  = 1'b1;
        ctrl.alu_b_sel  = B_IMM;
        ctrl.mem_wr     = (state == S_ST_MEM);
        ctrl.addr_sel   = (state == S_LD_MEM);
        ctrl.reg_wr     = (state == S_LD_WB);
        ctrl.mem_to_reg = (state == S_LD_WB);
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
#(
  parameter int              OP_W   = 6,
  parameter logic [OP_W-1:0] OP_REG = 6'b000000,
  parameter logic [OP_W-1:0] OP_ORI = 6'b001101,
  parameter logic [OP_W-1:0] OP_LW  = 6'b100011,
  parameter logic [OP_W-1:0] OP_SW  = 6'b101011,
  parameter logic [OP_W-1:0] OP_BEQ = 6'b000100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output logic            pc_wr,
  output logic            pc_wr_cond,
  output logic            ir_wr,
  output logic            br_wr,
  output logic            mem_wr,
  output logic            reg_wr,
  output logic            addr_sel,
  output logic            reg_dst,
  output logic            mem_to_reg,
  output logic            ext_sign,
  output logic            alu_a_sel,
  output logic [1:0]      alu_b_sel,
  output logic            pc_src,
  output logic [1:0]      alu_class
);

  state_t state;
  state_t nxt;
  ctrl_t  ctrl;

  mc_ctrl_next #(
    .OP_W(OP_W), .OP_REG(OP_REG), .OP_ORI(OP_ORI),
    .OP_LW(OP_LW), .OP_SW(OP_SW), .OP_BEQ(OP_BEQ)
  ) u_next (
    .state  (state),
    .opcode (opcode),
    .nxt    (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= nxt;
  end

  mc_ctrl_out u_out (
    .state (state),
    .ctrl  (ctrl)
  );

  assign pc_wr      = ctrl.pc_wr;
  assign pc_wr_cond = ctrl.pc_wr_cond;
  assign ir_wr      = ctrl.ir_wr;
  assign br_wr      = ctrl.br_wr;
  assign mem_wr     = ctrl.mem_wr;
  assign reg_wr     = ctrl.reg_wr;
  assign addr_sel   = ctrl.addr_sel;
  assign reg_dst    = ctrl.reg_dst;
  assign mem_to_reg = ctrl.mem_to_reg;
  assign ext_sign   = ctrl.ext_sign;
  assign alu_a_sel  = ctrl.alu_a_sel;
  assign alu_b_sel  = ctrl.alu_b_sel;
  assign pc_src     = ctrl.pc_src;
  assign alu_class  = ctrl.alu_class;

  // R1: the edge that samples reset leaves fetch outputs behind it
  a_r1_reset_to_fetch: assert property (@(posedge clk)
    $past(rst) |-> (ir_wr && pc_wr && !br_wr && !mem_wr && !reg_wr));

  // R10: a single write target per cycle, and PC and IR load together
  a_r10_one_writer: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_wr, mem_wr, pc_wr_cond, br_wr}));

  a_r10_ir_with_pc: assert property (@(posedge clk) disable iff (rst)
    ir_wr == pc_wr);

  // R3: decode lasts a single cycle
  a_r3_decode_once: assert property (@(posedge clk) disable iff (rst)
    br_wr |=> !br_wr);

  // R8: the memory write follows a cycle that already drove the address selects
  a_r8_write_after_calc: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> ($past(alu_a_sel) && $past(alu_b_sel) == 2'b11 &&
                $past(alu_class) == 2'b00 && !$past(mem_wr) &&
                $stable(alu_b_sel) && $stable(alu_a_sel)));

  // R5: the branch cycle is the last one of its instruction
  a_r5_branch_then_fetch: assert property (@(posedge clk) disable iff (rst)
    pc_wr_cond |=> ir_wr);

  // R9: a load read is followed by its write-back
  a_r9_read_then_wb: assert property (@(posedge clk) disable iff (rst)
    addr_sel |=> (reg_wr && mem_to_reg && !reg_dst));

endmodule

// File: tb/mc_ctrl_fsm_tb.sv
module mc_ctrl_fsm_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [5:0] K_REG = 6'b000000;
  localparam logic [5:0] K_ORI = 6'b001101;
  localparam logic [5:0] K_LW  = 6'b100011;
  localparam logic [5:0] K_SW  = 6'b101011;
  localparam logic [5:0] K_BEQ = 6'b000100;

  localparam int NV = 9;
  localparam logic [5:0] VOP  [NV] = '{K_LW, K_SW, K_REG, K_ORI, K_BEQ,
                                       6'b111111, 6'b000010, K_BEQ, K_LW};
  localparam int         VLEN [NV] = '{5, 4, 4, 4, 3, 2, 2, 3, 5};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = '0;
  logic pc_wr, pc_wr_cond, ir_wr, br_wr, mem_wr, reg_wr, addr_sel;
  logic reg_dst, mem_to_reg, ext_sign, alu_a_sel, pc_src;
  logic [1:0] alu_b_sel, alu_class;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  mc_ctrl_fsm u_dut (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .ir_wr(ir_wr), .br_wr(br_wr),
    .mem_wr(mem_wr), .reg_wr(reg_wr), .addr_sel(addr_sel), .reg_dst(reg_dst),
    .mem_to_reg(mem_to_reg), .ext_sign(ext_sign), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .pc_src(pc_src), .alu_class(alu_class)
  );

  logic [16:0] bus;
  assign bus = {pc_wr, pc_wr_cond, ir_wr, br_wr, mem_wr, reg_wr, addr_sel,
                reg_dst, mem_to_reg, ext_sign, alu_a_sel, alu_b_sel, pc_src,
                alu_class};

  // expected outputs per step of an instruction, from the requirements
  function automatic logic [16:0] exp_ctrl(input logic [5:0] op, input int s);
    logic pw = 0, pwc = 0, iw = 0, bw = 0, mw = 0, rw = 0, as = 0;
    logic rd = 0, m2r = 0, ex = 0, a = 0, ps = 0;
    logic [1:0] b = 2'b00, cl = 2'b00;
    if (s == 0) begin pw = 1; iw = 1; end
    else if (s == 1) begin bw = 1; ex = 1; b = 2'b10; end
    else if (op == K_BEQ && s == 2) begin
      pwc = 1; ps = 1; cl = 2'b01; a = 1; b = 2'b01;
    end else if (op == K_REG) begin
      cl = 2'b11; a = 1; b = 2'b01; rd = 1; rw = (s == 3);
    end else if (op == K_ORI) begin
      cl = 2'b10; a = 1; b = 2'b11; rw = (s == 3);
    end else if (op == K_SW || op == K_LW) begin
      ex = 1; a = 1; b = 2'b11;
      mw = (op == K_SW && s == 3);
      as = (op == K_LW && s == 3);
      rw = (op == K_LW && s == 4);
      m2r = rw;
    end
    return {pw, pwc, iw, bw, mw, rw, as, rd, m2r, ex, a, b, ps, cl};
  endfunction

  function automatic string tag_of(input logic [5:0] op, input int s);
    if (s == 0) return "R2";
    if (s == 1) return "R3";
    case (op)
      K_BEQ:   return "R5";
      K_REG:   return "R6";
      K_ORI:   return "R7";
      K_SW:    return "R8";
      K_LW:    return "R9";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [16:0] act, input logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_r10();
    n_chk++;
    if ($countones({reg_wr, mem_wr, pc_wr_cond, br_wr}) > 1 || ir_wr !== pc_wr) begin
      n_bad++;
      $display("FAIL R10 act=%b exp=exclusive", {reg_wr, mem_wr, pc_wr_cond, br_wr, ir_wr, pc_wr});
    end
  endtask

  // run one instruction from its fetch cycle, checking every cycle and its length
  task automatic run_instr(input logic [5:0] op, input int len);
    opcode = op;
    for (int s = 0; s < len; s++) begin
      chk(tag_of(op, s), bus, exp_ctrl(op, s));
      chk_r10();
      @(negedge clk);
    end
    chk({tag_of(op, 2), " length"}, {16'b0, ir_wr}, 17'd1);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset state", bus, exp_ctrl(K_REG, 0));

    // table walk
    for (int i = 0; i < NV; i++) run_instr(VOP[i], VLEN[i]);

    // R1: reset arriving in the load read cycle
    opcode = K_LW;
    for (int s = 0; s < 3; s++) @(negedge clk);
    chk("R9 read cycle", bus, exp_ctrl(K_LW, 3));
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid reset", bus, exp_ctrl(K_LW, 0));

    // R8: store after a reset, then R4 unknown opcode back to back
    run_instr(K_SW, 4);
    run_instr(6'b010101, 2);
    run_instr(K_ORI, 4);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule